// File: doc/BRIEF.md
# Power-up Mode Sequencer

This block decides when a fixed-function device leaves reset after power is applied. No real configuration takes place. A two-bit mode input is captured once, right after power-on reset ends. It picks one of three ways to become ready:

- **Immediate start:** leave reset right away.
- **Delayed start:** hold reset for a fixed timed delay, nominally 50 ms.
- **Configuration emulation:** count rising edges of an external configuration clock. The device is released only after as many edges as a real serial load would have needed.

The block drives an active-high reset for the user logic. It also drives an output-enable and data pair for an open-drain "configuration done" pin. The data level is always low. While the enable is asserted, the pin is pulled low. When the enable is dropped, an external pull-up raises the pin. Reset release and pin release always happen together. After release, the device stays released until the next power-on reset, whatever the mode and configuration inputs do.

The power-on reset input is asynchronous active-low and is released into the system clock through two flops. The configuration clock and configuration start inputs each pass through a two-stage synchroniser. Counting uses rising edges detected in the system clock domain.

Top module: `pwrup_mode_seq`

## Requirements
- R1: Mode encoding, read from `mode_sel` on the first clock edge after the internal reset releases: 2'b00 immediate, 2'b01 delayed, 2'b10 emulation, 2'b11 immediate. In immediate mode, `usr_rst` and `done_oe` both fall on the 3rd rising clock edge after `por_n` rises.
- R2: While `por_n` is low, `usr_rst` is 1 and `done_oe` is 1, asynchronously. `done_o` is 0 at all times.
- R3: In delayed mode, the release comes exactly DELAY_CYC clock cycles later than in immediate mode, where DELAY_CYC = CLK_HZ/1000*DELAY_MS.
- R4: In emulation mode, the release comes after CFG_CYCLES rising edges of `cfg_clk` seen while `cfg_start` is high. It does not come after CFG_CYCLES-1 such edges. It comes within 4 clock cycles of the last counted edge.
- R5: In emulation mode, `cfg_start` low clears the edge count. Edges seen while `cfg_start` is low are not counted.
- R6: In immediate and delayed modes, activity on `cfg_clk`, `cfg_start` and `cfg_data` does not change the release cycle.
- R7: `cfg_data` has no effect in any mode.
- R8: A change of `mode_sel` after it has been captured does not change behaviour until the next power-on reset.
- R9: Once released, `usr_rst` and `done_oe` stay 0 until `por_n` goes low, whatever the mode and configuration inputs do.
- R10: `usr_rst` and `done_oe` deassert on the same clock edge in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mode_sel | input | 2 | Power-up mode select, captured once |
| cfg_start | input | 1 | Configuration start; counting runs while high |
| cfg_clk | input | 1 | External configuration clock, asynchronous |
| cfg_data | input | 1 | Configuration data; accepted, not interpreted |
| usr_rst | output | 1 | Active-high reset for user logic |
| done_oe | output | 1 | Output enable of the open-drain done pin |
| done_o | output | 1 | Data level of the done pin (always 0) |

## Verification
The embedded assertions check the following on every cycle:
- the released state is never left;
- the captured mode is never altered;
- immediate modes never enter a waiting state;
- the edge count stays below its limit;
- a low start input clears the count;
- a detected configuration edge lasts one cycle.

The exact release cycle in each mode can only be shown by the bench scenarios. These include the delay length, the one-edge boundary in emulation, restarting the count when the start input is pulsed low, and immunity to noise on the configuration inputs and to late mode changes.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [1:0] {
    MODE_INSTANT = 2'b00,
    MODE_DELAY   = 2'b01,
    MODE_EMUL    = 2'b10,
    MODE_RSVD    = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_INIT = 2'b00,
    ST_WAIT = 2'b01,
    ST_EMUL = 2'b10,
    ST_DONE = 2'b11
  } seq_state_e;
endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/pwrup_bit_sync.sv
module pwrup_bit_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[b] <= '0;
      else        chain_q[b] <= {chain_q[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[b][STAGES-1];
  end
endmodule

// File: rtl/pwrup_tick_counter.sv
module pwrup_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign hit_o  = inc && !clr && (cnt_q == limit - W'(1));
  assign cnt_en = clr || inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || hit_o) cnt_d = '0;
    else if (inc)     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3 R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);
endmodule

// File: rtl/pwrup_mode_seq.sv
module pwrup_mode_seq #(
  parameter int CLK_HZ     = 250_000_000,
  parameter int DELAY_MS   = 50,
  parameter int CFG_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] mode_sel,
  input  logic       cfg_start,
  input  logic       cfg_clk,
  input  logic       cfg_data,
  output logic       usr_rst,
  output logic       done_oe,
  output logic       done_o
);
  import pwrup_pkg::*;

  localparam int DELAY_CYC = (CLK_HZ / 1000) * DELAY_MS;
  localparam int MAX_CNT   = (DELAY_CYC > CFG_CYCLES) ? DELAY_CYC : CFG_CYCLES;
  localparam int CW        = $clog2(MAX_CNT + 1);
  localparam logic [CW-1:0] DELAY_LIM = CW'(DELAY_CYC);
  localparam logic [CW-1:0] CFG_LIM   = CW'(CFG_CYCLES);

  logic          rst_n_sync;
  logic [1:0]    sync_q;
  logic          clk_s, start_s, clk_prev_q, cfg_rise;
  seq_state_e    state_q, state_d;
  pwr_mode_e     mode_q;
  logic          mode_en;
  logic          cnt_clr, cnt_inc, cnt_hit;
  logic [CW-1:0] cnt_limit, cnt_val;
  logic          cfg_data_unused;

  assign cfg_data_unused = cfg_data;

  pwrup_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (rst_n_sync)
  );

  pwrup_bit_sync #(.WIDTH(2), .STAGES(2)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d_i   ({cfg_start, cfg_clk}),
    .q_o   (sync_q)
  );

  assign clk_s   = sync_q[0];
  assign start_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) clk_prev_q <= 1'b0;
    else             clk_prev_q <= clk_s;
  end

  assign cfg_rise = clk_s && !clk_prev_q;

  pwrup_tick_counter #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .limit (cnt_limit),
    .cnt_o (cnt_val),
    .hit_o (cnt_hit)
  );

  always_comb begin
    state_d   = state_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    cnt_limit = DELAY_LIM;
    unique case (state_q)
      ST_INIT: begin
        cnt_clr = 1'b1;
        unique case (pwr_mode_e'(mode_sel))
          MODE_DELAY: state_d = ST_WAIT;
          MODE_EMUL:  state_d = ST_EMUL;
          default:    state_d = ST_DONE;
        endcase
      end
      ST_WAIT: begin
        cnt_inc = 1'b1;
        if (cnt_hit) state_d = ST_DONE;
      end
      ST_EMUL: begin
        cnt_limit = CFG_LIM;
        if (!start_s)      cnt_clr = 1'b1;
        else if (cfg_rise) cnt_inc = 1'b1;
        if (cnt_hit) state_d = ST_DONE;
      end
      default: state_d = ST_DONE;
    endcase
  end

  assign mode_en = (state_q == ST_INIT);

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) state_q <= ST_INIT;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  mode_q <= MODE_INSTANT;
    else if (mode_en) mode_q <= pwr_mode_e'(mode_sel);
  end

  assign usr_rst = (state_q != ST_DONE);
  assign done_oe = (state_q != ST_DONE);
  assign done_o  = 1'b0;

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    state_q == ST_DONE |=> state_q == ST_DONE);

  // R8
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    state_q != ST_INIT |=> $stable(mode_q));

  // R1
  instant_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state_q != ST_INIT && (mode_q == MODE_INSTANT || mode_q == MODE_RSVD))
      |-> state_q == ST_DONE);

  // R5
  start_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state_q == ST_EMUL && !start_s) |=> cnt_val == '0);

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cfg_rise |=> !cfg_rise);
endmodule

// File: tb/pwrup_mode_seq_tb.sv
module pwrup_mode_seq_tb_top;
  localparam int CLK_HZ     = 2000;
  localparam int DELAY_MS   = 50;
  localparam int CFG_CYCLES = 20;
  localparam int DCYC       = (CLK_HZ / 1000) * DELAY_MS;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       cfg_start = 1'b0, cfg_clk = 1'b0, cfg_data = 1'b0;
  logic       usr_rst, done_oe, done_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pwrup_mode_seq #(.CLK_HZ(CLK_HZ), .DELAY_MS(DELAY_MS), .CFG_CYCLES(CFG_CYCLES)) dut_i (
    .clk(clk), .por_n(por_n), .mode_sel(mode_sel), .cfg_start(cfg_start),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data), .usr_rst(usr_rst),
    .done_oe(done_oe), .done_o(done_o));

  function automatic int exp_release(input logic [1:0] m);
    return (m == 2'b01) ? 3 + DCYC : 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_cycle(input logic [1:0] m, input bit noise, input bit flip, output int n);
    bit track_ok = 1'b1;
    por_n = 1'b0; mode_sel = m;
    repeat (3) @(negedge clk);
    por_n = 1'b1; n = 0;
    while (n < 4 * DCYC) begin
      @(posedge clk); @(negedge clk); n++;
      if (usr_rst !== done_oe || done_o !== 1'b0) track_ok = 1'b0;
      if (usr_rst === 1'b0) break;
      if (noise) begin
        cfg_clk = 1'($urandom); cfg_start = 1'($urandom); cfg_data = 1'($urandom);
      end
      if (flip && n == 5) mode_sel = 2'b00;
    end
    check(track_ok, "R10 oe/reset same edge, done_o low", done_oe, usr_rst);
  endtask

  task automatic emu_pulse();
    cfg_data = 1'($urandom);
    cfg_clk = 1'b1; repeat (3) @(negedge clk);
    cfg_clk = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic after_release_noise();
    bit ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      mode_sel = 2'($urandom); cfg_clk = 1'($urandom);
      cfg_start = 1'($urandom); cfg_data = 1'($urandom);
      @(negedge clk);
      if (usr_rst !== 1'b0 || done_oe !== 1'b0) ok = 1'b0;
    end
    check(ok, "R9 R8 stays released", usr_rst, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    // R2 reset state
    @(negedge clk);
    check(usr_rst === 1'b1 && done_oe === 1'b1 && done_o === 1'b0,
          "R2 reset state", {usr_rst, done_oe, done_o}, 3'b110);

    // R1 immediate, reserved code
    power_cycle(2'b00, 1'b0, 1'b0, n);
    check(n == exp_release(2'b00), "R1 immediate release cycle", n, exp_release(2'b00));
    after_release_noise();
    power_cycle(2'b11, 1'b0, 1'b0, n);
    check(n == exp_release(2'b11), "R1 code 11 immediate", n, exp_release(2'b11));

    // R2 asynchronous reassertion
    #1 por_n = 1'b0; #0.5;
    check(usr_rst === 1'b1 && done_oe === 1'b1, "R2 async assert", usr_rst, 1);

    // R3 delayed
    power_cycle(2'b01, 1'b0, 1'b0, n);
    check(n == exp_release(2'b01), "R3 delayed release cycle", n, exp_release(2'b01));
    after_release_noise();

    // R8 late mode change
    power_cycle(2'b01, 1'b0, 1'b1, n);
    check(n == exp_release(2'b01), "R8 mode change ignored", n, exp_release(2'b01));

    // R6 R7 random modes with input noise
    for (int k = 0; k < 8; k++) begin
      logic [1:0] m;
      case ($urandom_range(0, 2))
        0: m = 2'b00;
        1: m = 2'b01;
        default: m = 2'b11;
      endcase
      power_cycle(m, 1'b1, 1'b0, n);
      check(n == exp_release(m), "R6 R7 noise ignored", n, exp_release(m));
    end

    // R4 R5 emulation
    por_n = 1'b0; mode_sel = 2'b10; cfg_start = 1'b0; cfg_clk = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (10) @(negedge clk);
    repeat (CFG_CYCLES + 2) emu_pulse();
    check(usr_rst === 1'b1, "R5 edges with start low not counted", usr_rst, 1);
    cfg_start = 1'b1; repeat (4) @(negedge clk);
    repeat (10) emu_pulse();
    cfg_start = 1'b0; repeat (5) @(negedge clk);
    cfg_start = 1'b1; repeat (5) @(negedge clk);
    repeat (CFG_CYCLES - 1) emu_pulse();
    repeat (6) @(negedge clk);
    check(usr_rst === 1'b1 && done_oe === 1'b1, "R5 count restarted", usr_rst, 1);
    emu_pulse();
    check(usr_rst === 1'b0 && done_oe === 1'b0, "R4 release after last edge", usr_rst, 0);
    after_release_noise();

    // R4 clean run, exact boundary
    por_n = 1'b0; cfg_start = 1'b0; mode_sel = 2'b10;
    repeat (3) @(negedge clk);
    por_n = 1'b1; cfg_start = 1'b1; repeat (6) @(negedge clk);
    repeat (CFG_CYCLES - 1) emu_pulse();
    check(usr_rst === 1'b1, "R4 not released one edge short", usr_rst, 1);
    cfg_clk = 1'b1;
    repeat (4) @(negedge clk);
    check(usr_rst === 1'b0 && done_oe === 1'b0, "R4 released within 4 cycles", usr_rst, 0);
    cfg_clk = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule